// File: doc/BRIEF.md
# Serial LFSR Polynomial Divider

This block is a linear feedback shift register of parameterised length `K` whose feedback taps come from a degree-`K` polynomial over GF(2). It has two modes of operation.

In free-running mode it needs no data input. It advances on every clock and walks through the nonzero states of the register. With a primitive polynomial it visits every one of the `2^K - 1` nonzero states before it repeats.

In divide mode a serial bit stream enters the low end of the register, highest-order coefficient first. The register divides that stream, read as a polynomial, by the tap polynomial. The bits that leave the high end are the quotient. The state left after the last bit is the remainder, which serves as a compact signature of the stream.

A synchronous load sets the register to a seed. In divide mode the seed is normally zero. In free-running mode an all-zero seed is replaced by a fixed nonzero value, so the register can never stall in the all-zero state.

Top module: `lfsr_div`

## Requirements
- R1: While `rst` is high at a rising clock edge, `state` becomes all zeros and `q_bit` becomes 0.
- R2: When `load` is high at an edge, `state` takes `seed` on that edge, except in the case covered by R3. `load` takes priority over any advance in either mode.
- R3: In free-running mode (`mode` = 0), loading an all-zero seed puts the safe value 1 (only bit 0 set) into `state`.
- R4: In free-running mode the register advances on every edge without `load`. Bit 0 takes the old top bit. Each bit i > 0 takes old bit i-1, XORed with the old top bit when `POLY[i]` is 1. `POLY[i]` is the coefficient of x^i, and x^K is implied. Starting from 1, after t steps the state equals x^t mod P(x).
- R5: With the default primitive polynomial x^8+x^4+x^3+x^2+1 (`POLY` = 8'h1D), a nonzero free-running seed returns for the first time after exactly 255 steps. The state is never zero on the way.
- R6: In divide mode (`mode` = 1), the register advances only on edges where `valid` is high. Otherwise `state` and `q_bit` hold.
- R7: In divide mode, bit 0 takes `din` XOR the old top bit. The upper bits follow the same rule as in R4.
- R8: On every advance, `q_bit` takes the old top bit of `state`, which is the bit shifted out.
- R9: For an n-bit stream fed from a zero state, the `q_bit` values over the n advances are K zeros followed by the quotient coefficients from degree n-K-1 down to 0. After the last bit, `state` holds the remainder, with bit i being the coefficient of x^i.
- R10: In free-running mode without `load`, an all-zero state is replaced by the safe value 1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load `seed` into the register |
| seed | input | K | Seed value |
| mode | input | 1 | 0 = free-running, 1 = divide |
| din | input | 1 | Serial dividend bit, highest order first |
| valid | input | 1 | Advance strobe for divide mode |
| q_bit | output | 1 | Last bit shifted out (quotient bit) |
| state | output | K | Register contents (remainder in divide mode) |

## Verification
The bench compares each quotient bit and every final remainder against its own long division for random streams, including streams shorter than `K` and streams with idle gaps. A register that fed back from the wrong cell, or that advanced on idle cycles, would give a wrong quotient or signature.

In free-running mode the bench checks the state sequence against powers of x modulo the polynomial, and measures the period from a loaded seed. A wrong tap would shorten the cycle or change the sequence. A missing zero guard would leave the register stuck at zero after a zero seed or after a zero remainder.

A 3-bit instance divides x^6+x^3+x+1 by x^3+x+1 and must give quotient 1010 and remainder 101.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

    localparam int             DEF_K    = 8;
    localparam logic [DEF_K-1:0] DEF_POLY = 8'h1D;

    typedef enum logic {
        MODE_AUTO = 1'b0,
        MODE_SIG  = 1'b1
    } mode_e;

    typedef struct packed {
        logic do_load;   // take seed this edge
        logic advance;   // shift this edge
        logic zero_fix;  // substitute the safe nonzero value
        logic feed;      // serial bit entering cell 0
    } step_t;

    function automatic mode_e to_mode(input logic m);
        return m ? MODE_SIG : MODE_AUTO;
    endfunction

endpackage

// File: rtl/lfsr_div_ctrl.sv
module lfsr_div_ctrl
    import lfsr_div_pkg::*;
(
    input  logic  load,
    input  logic  mode,
    input  logic  valid,
    input  logic  din,
    input  logic  seed_zero,
    input  logic  state_zero,
    output step_t step
);
    mode_e md;

    always_comb begin
        md            = to_mode(mode);
        step.do_load  = load;
        step.advance  = !load && ((md == MODE_AUTO) || valid);
        step.zero_fix = (md == MODE_AUTO) && (load ? seed_zero : state_zero);
        step.feed     = (md == MODE_SIG) && din;
    end
endmodule

// File: rtl/lfsr_div_next.sv
module lfsr_div_next #(
    parameter int             K    = 8,
    parameter logic [K-1:0]   POLY = 8'h1D
) (
    input  logic [K-1:0] cur,
    input  logic         feed,
    output logic [K-1:0] nxt
);
    logic top;
    assign top = cur[K-1];

    for (genvar i = 0; i < K; i++) begin : g_cell
        logic shifted;
        if (i == 0) begin : g_lo
            assign shifted = feed;
        end else begin : g_hi
            assign shifted = cur[i-1];
        end
        if (POLY[i]) begin : g_tap
            assign nxt[i] = shifted ^ top;
        end else begin : g_plain
            assign nxt[i] = shifted;
        end
    end
endmodule

// File: rtl/lfsr_div.sv
module lfsr_div
    import lfsr_div_pkg::*;
#(
    parameter int           K    = DEF_K,
    parameter logic [K-1:0] POLY = DEF_POLY
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [K-1:0] seed,
    input  logic         mode,
    input  logic         din,
    input  logic         valid,
    output logic         q_bit,
    output logic [K-1:0] state
);
    localparam logic [K-1:0] SAFE = {{(K-1){1'b0}}, 1'b1};

    step_t        step;
    logic [K-1:0] nxt;

    lfsr_div_ctrl u_ctrl (
        .load       (load),
        .mode       (mode),
        .valid      (valid),
        .din        (din),
        .seed_zero  (seed == '0),
        .state_zero (state == '0),
        .step       (step)
    );

    lfsr_div_next #(.K(K), .POLY(POLY)) u_next (
        .cur  (state),
        .feed (step.feed),
        .nxt  (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
            q_bit <= 1'b0;
        end else if (step.do_load) begin
            state <= step.zero_fix ? SAFE : seed;
        end else if (step.advance) begin
            state <= step.zero_fix ? SAFE : nxt;
            q_bit <= state[K-1];
        end
    end
endmodule

// File: rtl/lfsr_div_chk.sv
module lfsr_div_chk #(
    parameter int K = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         load,
    input logic [K-1:0] seed,
    input logic         mode,
    input logic         valid,
    input logic         q_bit,
    input logic [K-1:0] state
);
    localparam logic [K-1:0] SAFE = {{(K-1){1'b0}}, 1'b1};

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (state == '0) && !q_bit);

    a_r2_load_seed: assert property (@(posedge clk) disable iff (rst)
        (load && (mode || seed != '0)) |=> state == $past(seed));

    a_r3_zero_seed: assert property (@(posedge clk) disable iff (rst)
        (load && !mode && seed == '0) |=> state == SAFE);

    a_r5_never_zero: assert property (@(posedge clk) disable iff (rst)
        (!load && !mode && state != '0) |=> state != '0);

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (mode && !valid && !load) |=> $stable(state) && $stable(q_bit));

    a_r8_shift_out: assert property (@(posedge clk) disable iff (rst)
        (mode && valid && !load) |=> q_bit == $past(state[K-1]));

    a_r10_unstick: assert property (@(posedge clk) disable iff (rst)
        (!load && !mode && state == '0) |=> state == SAFE);
endmodule

bind lfsr_div lfsr_div_chk #(.K(K)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .load  (load),
    .seed  (seed),
    .mode  (mode),
    .valid (valid),
    .q_bit (q_bit),
    .state (state)
);

// File: tb/sim_lfsr_div.sv
module sim_lfsr_div;
    localparam int           K    = 8;
    localparam logic [K-1:0] POLY = 8'h1D;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic [K-1:0] seed = '0;
    logic         mode = 1'b1;
    logic         din = 1'b0;
    logic         valid = 1'b0;
    logic         q_bit;
    logic [K-1:0] state;
    logic         q1;
    logic [2:0]   st1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic exp_q[$];
    logic [15:0] u1_hist = '0;

    always #2 clk = ~clk;

    lfsr_div #(.K(K), .POLY(POLY)) u0 (
        .clk(clk), .rst(rst), .load(load), .seed(seed), .mode(mode),
        .din(din), .valid(valid), .q_bit(q_bit), .state(state));

    lfsr_div #(.K(3), .POLY(3'b011)) u1 (
        .clk(clk), .rst(rst), .load(load), .seed(3'b000), .mode(mode),
        .din(din), .valid(valid), .q_bit(q1), .state(st1));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // plain GF(2) long division of an n-bit dividend by p (degree k)
    task automatic gf_div(input longint unsigned d, input int n, input longint unsigned p,
                          input int k, output longint unsigned q, output longint unsigned r);
        q = 0;
        for (int deg = n - 1; deg >= k; deg--) begin
            if (d[deg]) begin
                d = d ^ (p << (deg - k));
                q[deg - k] = 1'b1;
            end
        end
        r = d;
    endtask

    // monitor: compare every shifted-out bit against the scoreboard (R8, R9)
    always @(posedge clk) begin
        if (!rst && mode && valid && !load) begin
            #1;
            u1_hist = {u1_hist[14:0], q1};
            if (exp_q.size() == 0) begin
                chk("R8 unexpected advance", 1, 0);
            end else begin
                chk("R9 quotient bit", q_bit, exp_q.pop_front());
            end
        end
    end

    task automatic run_stream(input longint unsigned d, input int n, input bit gaps);
        longint unsigned q, r, full;
        logic [K-1:0] hold;
        logic hq;
        full = (64'd1 << K) | POLY;
        gf_div(d, n, full, K, q, r);
        @(negedge clk);
        mode = 1'b1; load = 1'b1; seed = '0; valid = 1'b0;
        @(negedge clk);
        load = 1'b0;
        for (int j = 0; j < n; j++) exp_q.push_back((j < K) ? 1'b0 : q[n - 1 - j]);
        for (int j = n - 1; j >= 0; j--) begin
            din = d[j]; valid = 1'b1;
            @(negedge clk);
            if (gaps && ($urandom % 3 == 0)) begin
                valid = 1'b0; din = $urandom;
                hold = state; hq = q_bit;
                @(negedge clk);
                chk("R6 idle state", state, hold);
                chk("R6 idle q_bit", q_bit, hq);
            end
        end
        valid = 1'b0;
        chk("R9 remainder", state, r[K-1:0]);
        chk("R9 quotient drained", exp_q.size(), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        longint unsigned q, r, full;
        int cnt;
        bit saw_zero;
        full = (64'd1 << K) | POLY;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset state", state, 0);
        chk("R1 reset q_bit", q_bit, 0);

        // R10 then R4: zero state in free-running mode, then powers of x
        mode = 1'b0;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            gf_div(64'd1 << t, t + 1, full, K, q, r);
            chk(t == 0 ? "R10 unstick" : "R4 step sequence", state, r);
        end

        // R2 and R5: seed load and full period
        load = 1'b1; seed = 8'h5A;
        @(negedge clk);
        load = 1'b0;
        chk("R2 load seed", state, 8'h5A);
        cnt = 0; saw_zero = 0;
        for (int i = 1; i <= 300; i++) begin
            @(negedge clk);
            if (state == '0) saw_zero = 1;
            if (state == 8'h5A) begin cnt = i; break; end
        end
        chk("R5 period", cnt, 255);
        chk("R5 no zero state", saw_zero, 0);

        // R3: zero seed replaced
        load = 1'b1; seed = '0;
        @(negedge clk);
        load = 1'b0;
        chk("R3 zero seed", state, 1);

        // R2: load beats valid in divide mode
        mode = 1'b1; valid = 1'b1; din = 1'b1; load = 1'b1; seed = 8'hC3;
        @(negedge clk);
        load = 1'b0; valid = 1'b0;
        chk("R2 load priority", state, 8'hC3);

        // R6: idle cycles hold
        repeat (3) @(negedge clk);
        chk("R6 hold without valid", state, 8'hC3);

        // R7/R9: 3-bit worked example on u1, also divided by u0
        u1_hist = '0;
        run_stream(64'b1001011, 7, 0);
        chk("R9 k3 remainder", st1, 3'b101);
        chk("R7 k3 quotient stream", u1_hist[6:0], 7'b0001010);

        // R7/R9/R6: random streams, some with idle gaps
        run_stream({$urandom, $urandom} & 64'hFF, 8, 0);
        run_stream({$urandom, $urandom} & 64'h1FFF, 13, 1);
        run_stream({$urandom, $urandom} & 64'h1FFFFF, 21, 0);
        run_stream({32'd0, $urandom}, 32, 1);
        run_stream({$urandom, $urandom} & 64'hFFFFFFFFFF, 40, 1);
        run_stream(64'd5, 3, 0);

        // R10: a zero remainder switched to free-running mode recovers
        run_stream(64'h11D, 9, 0);
        @(negedge clk);
        mode = 1'b0;
        @(negedge clk);
        chk("R10 zero remainder recovers", state, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule